// File: doc/BRIEF.md
# Shared Memory Arbiter with Atomic Compare-Exchange

This block sits between several processor ports and one word-addressed memory that it owns. Each port presents a request (an operation code, a program-counter value, an address offset and two register operands) and holds it until it sees its ready line. The block then serves that request alone and returns a result word, an error flag and a one-cycle done pulse on the same port. Only one port is served at a time. When several ports wait, the next one is chosen in rotating order.

The block serves direct loads and stores at PC plus offset, and indirect loads and stores at a base register plus offset. It also serves two identity queries (own port number and port count) and an atomic compare-exchange. For the compare-exchange, the bus stays locked from the read, through the comparison, to the conditional write. No other port can be granted in between. A failed comparison hands back the memory word it found. Any effective address at or beyond the memory depth halts the request with an error and leaves memory untouched.

Top module: `mp_cmpxchg_arbiter`

## Requirements
- R1: After reset no ready, done or error line is high, every memory word reads zero, and the first contended grant goes to port 0.
- R2: At most one ready line is high in a cycle. Among waiting ports, the grant goes to the first requester at or after the port following the last one granted, wrapping past the highest port.
- R3: Opcode 0x01 returns the word at address pc+off and opcode 0x02 writes operand a there. The sum wraps at the data width.
- R4: Opcode 0x05 returns the word at address b+off and opcode 0x06 writes operand a there. The sum wraps at the data width.
- R5: Opcode 0x15 (compare-exchange at pc+off): when operand a equals the memory word, the word becomes operand b and the result is operand a.
- R6: Opcode 0x15 when operand a differs from the memory word: memory is unchanged and the result is the memory word.
- R7: From the grant of a compare-exchange until its done pulse, no other port receives ready. Of several simultaneous exchanges that expect the same old value, exactly one succeeds.
- R8: An effective address not below the memory depth gives done with error set and result 0, and writes no memory word.
- R9: Opcode 0x16 returns the requesting port's index, and opcode 0x17 returns the port count.
- R10: The done pulse lasts one cycle and comes on the second rising edge after the accepting edge, or on the third for a compare-exchange that writes.
- R11: Any other opcode gives done with error set and changes no memory word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | NPORT | Per-port request pending |
| req_op | input | NPORT x 8 | Per-port operation code |
| req_pc | input | NPORT x DW | Per-port program-counter value |
| req_off | input | NPORT x DW | Per-port address offset |
| req_a | input | NPORT x DW | Per-port first operand (store data, expected value) |
| req_b | input | NPORT x DW | Per-port second operand (base address, swap value) |
| req_ready | output | NPORT | Request accepted at the next rising edge |
| rsp_done | output | NPORT | One-cycle completion pulse |
| rsp_err | output | NPORT | Halt-with-error, valid with done |
| rsp_data | output | NPORT x DW | Result word, valid with done |

## Verification
The functions that can collide in one cycle are rotating arbitration and the compare-exchange lock. A port that starts requesting while another port's exchange is between its read and its write must not be granted until that exchange's done pulse. To provoke this, the bench starts one port's exchange and raises a second port's request one cycle later. It also launches four exchanges in the same cycle, all expecting the same old value. The bench judges the outcome by two things. First, the cycle of the second grant must not come before the first done. Second, exactly one exchange may succeed, and every losing exchange must get back the value the winner wrote.

// File: rtl/mpx_pkg.sv
// Package: shared opcode values, controller states and request kinds for
// the shared-memory arbiter. Assumes 8-bit operation codes.
package mpx_pkg;

    localparam logic [7:0] OP_LOAD    = 8'h01;
    localparam logic [7:0] OP_STORE   = 8'h02;
    localparam logic [7:0] OP_LDIND   = 8'h05;
    localparam logic [7:0] OP_STIND   = 8'h06;
    localparam logic [7:0] OP_CMPXCHG = 8'h15;
    localparam logic [7:0] OP_GETPID  = 8'h16;
    localparam logic [7:0] OP_GETCNT  = 8'h17;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXEC = 2'd1,
        ST_SWAP = 2'd2
    } mpx_state_e;

    typedef enum logic [2:0] {
        K_READ  = 3'd0,
        K_WRITE = 3'd1,
        K_CAS   = 3'd2,
        K_PID   = 3'd3,
        K_CNT   = 3'd4,
        K_BAD   = 3'd5
    } mpx_kind_e;

endpackage

// File: rtl/mpx_rr_arbiter.sv
// Rotating-priority arbiter. Picks the first requester at or after the
// pointer, and moves the pointer past the winner whenever a grant is issued.
// Assumes the caller holds enable low while the bus is busy or locked.
module mpx_rr_arbiter #(
    parameter int NPORT = 4,
    localparam int PW = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [NPORT-1:0] req,
    output logic [NPORT-1:0] grant,
    output logic [PW-1:0]    grant_idx
);

    logic [PW-1:0] ptr_q;
    logic          found;

    // Search the request vector starting at the pointer.
    always_comb begin
        found     = 1'b0;
        grant_idx = '0;
        for (int i = 0; i < NPORT; i++) begin
            int j;
            j = int'(ptr_q) + i;
            if (j >= NPORT) j = j - NPORT;
            if (!found && req[j]) begin
                found     = 1'b1;
                grant_idx = PW'(j);
            end
        end
    end

    // Gate the one-hot grant by enable and by a winner being found.
    always_comb begin
        grant = '0;
        if (enable && found) grant[grant_idx] = 1'b1;
    end

    // Advance the pointer to the port after the winner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (enable && found) begin
            if (int'(grant_idx) == NPORT - 1) ptr_q <= '0;
            else                              ptr_q <= grant_idx + PW'(1);
        end
    end

    p_grant_requested_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req) == '0);

    p_grant_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

endmodule

// File: rtl/mpx_decode.sv
// Request decoder. Maps an operation code to a request kind and forms the
// effective address: PC-relative for direct and exchange requests, and
// base-relative for indirect ones. The sum wraps at the data width.
module mpx_decode
    import mpx_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [7:0]    op,
    input  logic [DW-1:0] pc,
    input  logic [DW-1:0] off,
    input  logic [DW-1:0] base,
    output mpx_kind_e     kind,
    output logic [DW-1:0] addr
);

    // Classify the opcode and select the address base.
    always_comb begin
        kind = K_BAD;
        addr = '0;
        unique case (op)
            OP_LOAD:    begin kind = K_READ;  addr = pc + off;   end
            OP_STORE:   begin kind = K_WRITE; addr = pc + off;   end
            OP_LDIND:   begin kind = K_READ;  addr = base + off; end
            OP_STIND:   begin kind = K_WRITE; addr = base + off; end
            OP_CMPXCHG: begin kind = K_CAS;   addr = pc + off;   end
            OP_GETPID:  kind = K_PID;
            OP_GETCNT:  kind = K_CNT;
            default:    kind = K_BAD;
        endcase
    end

endmodule

// File: rtl/mpx_word_store.sv
// Word memory owned by the arbiter: reads are combinational and the single
// write port is synchronous. All words clear on reset. Assumes the caller
// only writes in-range indices.
module mpx_word_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 16,
    localparam int MW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [MW-1:0] idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] words [DEPTH];

    genvar w;
    generate
        for (w = 0; w < DEPTH; w++) begin : g_word
            // Hold one word; load it when the write index selects it.
            always_ff @(posedge clk) begin
                if (!rst_n)                           words[w] <= '0;
                else if (we && int'(idx) == w)        words[w] <= wdata;
            end
        end
    endgenerate

    // Read the addressed word, returning zero for an index past the depth.
    always_comb begin
        rdata = '0;
        if (int'(idx) < DEPTH) rdata = words[idx];
    end

    p_write_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (int'(idx) < DEPTH));

endmodule

// File: rtl/mp_cmpxchg_arbiter.sv
// Shared-memory arbiter with an atomic compare-exchange. It serves one port
// at a time. An exchange keeps the bus locked from its read to its
// conditional write, and results return on the requester's lane with a
// one-cycle done pulse. Assumes a port holds its request fields steady
// until it sees ready.
module mp_cmpxchg_arbiter
    import mpx_pkg::*;
#(
    parameter int NPORT = 4,
    parameter int DEPTH = 16,
    parameter int DW    = 16,
    localparam int PW = (NPORT > 1) ? $clog2(NPORT) : 1,
    localparam int MW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NPORT-1:0]          req_valid,
    input  logic [NPORT-1:0][7:0]     req_op,
    input  logic [NPORT-1:0][DW-1:0]  req_pc,
    input  logic [NPORT-1:0][DW-1:0]  req_off,
    input  logic [NPORT-1:0][DW-1:0]  req_a,
    input  logic [NPORT-1:0][DW-1:0]  req_b,
    output logic [NPORT-1:0]          req_ready,
    output logic [NPORT-1:0]          rsp_done,
    output logic [NPORT-1:0]          rsp_err,
    output logic [NPORT-1:0][DW-1:0]  rsp_data
);

    mpx_state_e    state;
    logic [PW-1:0] g_idx;
    logic [PW-1:0] cur_q;
    mpx_kind_e     kind_q;
    mpx_kind_e     sel_kind;
    logic [DW-1:0] addr_q, a_q, b_q;
    logic [DW-1:0] sel_addr;
    logic [7:0]    sel_op;
    logic [DW-1:0] sel_pc, sel_off, sel_a, sel_b;
    logic          in_range;
    logic [DW-1:0] rdata;
    logic          mem_we;
    logic [DW-1:0] mem_wdata;
    logic          cas_hit;
    logic          fin, fin_err;
    logic [DW-1:0] fin_data;
    logic [NPORT-1:0] done_q, err_q;
    logic [DW-1:0] data_q;
    logic          idle;

    assign idle = (state == ST_IDLE);

    mpx_rr_arbiter #(.NPORT(NPORT)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (idle),
        .req       (req_valid),
        .grant     (req_ready),
        .grant_idx (g_idx)
    );

    // Steer the winning port's request fields to the decoder.
    always_comb begin
        sel_op  = req_op[g_idx];
        sel_pc  = req_pc[g_idx];
        sel_off = req_off[g_idx];
        sel_a   = req_a[g_idx];
        sel_b   = req_b[g_idx];
    end

    mpx_decode #(.DW(DW)) u_dec (
        .op   (sel_op),
        .pc   (sel_pc),
        .off  (sel_off),
        .base (sel_b),
        .kind (sel_kind),
        .addr (sel_addr)
    );

    assign in_range  = (addr_q < DW'(DEPTH));
    assign cas_hit   = (state == ST_EXEC) && (kind_q == K_CAS) && in_range && (rdata == a_q);
    assign mem_we    = ((state == ST_EXEC) && (kind_q == K_WRITE) && in_range) || (state == ST_SWAP);
    assign mem_wdata = (state == ST_SWAP) ? b_q : a_q;

    mpx_word_store #(.DEPTH(DEPTH), .DW(DW)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .idx   (addr_q[MW-1:0]),
        .wdata (mem_wdata),
        .rdata (rdata)
    );

    // Sequence the controller: accept, execute, optional locked write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cur_q  <= '0;
            kind_q <= K_BAD;
            addr_q <= '0;
            a_q    <= '0;
            b_q    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (|req_valid) begin
                    state  <= ST_EXEC;
                    cur_q  <= g_idx;
                    kind_q <= sel_kind;
                    addr_q <= sel_addr;
                    a_q    <= sel_a;
                    b_q    <= sel_b;
                end
                ST_EXEC: state <= cas_hit ? ST_SWAP : ST_IDLE;
                ST_SWAP: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Decide whether this cycle completes the request, and with what result.
    always_comb begin
        fin      = 1'b0;
        fin_err  = 1'b0;
        fin_data = '0;
        if (state == ST_EXEC) begin
            unique case (kind_q)
                K_READ: begin
                    fin = 1'b1;
                    if (in_range) fin_data = rdata;
                    else          fin_err  = 1'b1;
                end
                K_WRITE: begin
                    fin     = 1'b1;
                    fin_err = !in_range;
                end
                K_CAS: begin
                    if (!in_range) begin
                        fin     = 1'b1;
                        fin_err = 1'b1;
                    end else if (rdata != a_q) begin
                        fin      = 1'b1;
                        fin_data = rdata;
                    end
                end
                K_PID: begin
                    fin      = 1'b1;
                    fin_data = DW'(cur_q);
                end
                K_CNT: begin
                    fin      = 1'b1;
                    fin_data = DW'(NPORT);
                end
                default: begin
                    fin     = 1'b1;
                    fin_err = 1'b1;
                end
            endcase
        end else if (state == ST_SWAP) begin
            fin      = 1'b1;
            fin_data = a_q;
        end
    end

    // Register the response onto the owning port's lane for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= '0;
            err_q  <= '0;
            data_q <= '0;
        end else begin
            for (int p = 0; p < NPORT; p++) begin
                done_q[p] <= fin && (int'(cur_q) == p);
                err_q[p]  <= fin && fin_err && (int'(cur_q) == p);
            end
            data_q <= fin_data;
        end
    end

    // Present the result only on the lane whose done is high.
    always_comb begin
        for (int p = 0; p < NPORT; p++) begin
            rsp_data[p] = done_q[p] ? data_q : '0;
        end
    end
    assign rsp_done = done_q;
    assign rsp_err  = err_q;

    p_one_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_ready));

    p_one_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_done));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|rsp_done) |=> (rsp_done == '0));

    p_err_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_err & ~rsp_done) == '0);

    p_ready_starts_exec_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_ready) |=> (state == ST_EXEC));

    p_swap_owner_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SWAP) |-> ($past(state) == ST_EXEC && $stable(cur_q) && $stable(addr_q)));

    p_swap_matched_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SWAP) |-> ($past(kind_q) == K_CAS && $past(rdata) == a_q));

endmodule

// File: tb/sim_mp_cmpxchg_arbiter.sv
`timescale 1ns/1ps
module sim_mp_cmpxchg_arbiter;
    localparam int N = 4;
    localparam int D = 16;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic         v   [N];
    logic [7:0]   o   [N];
    logic [W-1:0] pcv [N], ofv [N], av [N], bv [N];

    logic [N-1:0]        req_valid, req_ready, rsp_done, rsp_err;
    logic [N-1:0][7:0]   req_op;
    logic [N-1:0][W-1:0] req_pc, req_off, req_a, req_b, rsp_data;

    always_comb begin
        for (int p = 0; p < N; p++) begin
            req_valid[p] = v[p];
            req_op[p]    = o[p];
            req_pc[p]    = pcv[p];
            req_off[p]   = ofv[p];
            req_a[p]     = av[p];
            req_b[p]     = bv[p];
        end
    end

    mp_cmpxchg_arbiter #(.NPORT(N), .DEPTH(D), .DW(W)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_pc(req_pc), .req_off(req_off), .req_a(req_a), .req_b(req_b),
        .req_ready(req_ready), .rsp_done(rsp_done), .rsp_err(rsp_err),
        .rsp_data(rsp_data)
    );

    int nchk = 0, nfail = 0, cyc = 0, multi_rdy = 0, n_order = 0;
    int gnt_at [N], done_at [N], lat [N], order_log [32];
    logic [W-1:0] got [N];
    logic         gerr [N];
    bit           finished = 0;

    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) if ($countones(req_ready) > 1) multi_rdy <= multi_rdy + 1;

    function automatic logic [W-1:0] fill(int a);
        return W'(a * 37 + 5);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(int p, logic [7:0] op, logic [W-1:0] pc, logic [W-1:0] off,
                         logic [W-1:0] a, logic [W-1:0] b);
        @(negedge clk);
        o[p] = op; pcv[p] = pc; ofv[p] = off; av[p] = a; bv[p] = b; v[p] = 1'b1;
        #2;
        while (!req_ready[p]) begin
            @(negedge clk);
            #2;
        end
        gnt_at[p] = cyc;
        order_log[n_order] = p;
        n_order++;
        @(negedge clk);
        v[p] = 1'b0;
        lat[p] = 1;
        while (!rsp_done[p]) begin
            @(negedge clk);
            lat[p]++;
        end
        got[p] = rsp_data[p];
        gerr[p] = rsp_err[p];
        done_at[p] = cyc;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        nfail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int p = 0; p < N; p++) begin
            v[p] = 0; o[p] = 0; pcv[p] = 0; ofv[p] = 0; av[p] = 0; bv[p] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        chk("R1 ready", 32'(req_ready), 0);
        chk("R1 done", 32'(rsp_done), 0);
        chk("R1 err", 32'(rsp_err), 0);

        // R1/R2/R9/R10: four simultaneous id queries, rotating order from port 0
        n_order = 0;
        fork
            issue(0, 8'h16, 0, 0, 0, 0);
            issue(1, 8'h16, 0, 0, 0, 0);
            issue(2, 8'h16, 0, 0, 0, 0);
            issue(3, 8'h16, 0, 0, 0, 0);
        join
        chk("R1 first grant", 32'(order_log[0]), 0);
        for (int i = 1; i < N; i++) chk("R2 order", 32'(order_log[i]), 32'(i));
        for (int p = 0; p < N; p++) begin
            chk("R9 pid", 32'(got[p]), 32'(p));
            chk("R10 latency", 32'(lat[p]), 2);
        end

        // R2: pointer now at 0; ports 3 and 1 race, then ports 2 and 0
        n_order = 0;
        fork
            issue(3, 8'h17, 0, 0, 0, 0);
            issue(1, 8'h17, 0, 0, 0, 0);
        join
        chk("R2 skip idle", 32'(order_log[0]), 1);
        chk("R2 skip idle", 32'(order_log[1]), 3);
        chk("R9 count", 32'(got[3]), 32'(N));
        n_order = 0;
        fork
            issue(2, 8'h17, 0, 0, 0, 0);
            issue(0, 8'h17, 0, 0, 0, 0);
        join
        chk("R2 wrap", 32'(order_log[0]), 0);
        chk("R2 wrap", 32'(order_log[1]), 2);
        chk("R9 count", 32'(got[0]), 32'(N));

        // R1: memory reads zero after reset
        issue(1, 8'h01, 16'd3, 16'd4, 0, 0);
        chk("R1 mem zero", 32'(got[1]), 0);

        // R3/R4: write every word (direct for even, indirect for odd), read back crosswise
        for (int a = 0; a < D; a++) begin
            if (a % 2 == 0) issue(a % N, 8'h02, W'(a / 2), W'(a - a / 2), fill(a), 0);
            else            issue(a % N, 8'h06, 0, 16'hFF9C, fill(a), W'(a + 100));
            chk(a % 2 == 0 ? "R3 store err" : "R4 stind err", 32'(gerr[a % N]), 0);
        end
        for (int a = 0; a < D; a++) begin
            int p = (a + 1) % N;
            if (a % 2 == 0) issue(p, 8'h05, 0, 16'd3, 0, W'(a - 3));
            else            issue(p, 8'h01, 16'hFFFF, W'(a + 1), 0, 0);
            chk(a % 2 == 0 ? "R4 ldind data" : "R3 load data", 32'(got[p]), 32'(fill(a)));
        end

        // R8: out-of-range accesses report error and leave memory alone
        issue(0, 8'h01, 16'd16, 0, 0, 0);
        chk("R8 load err", 32'(gerr[0]), 1);
        chk("R8 load data", 32'(got[0]), 0);
        issue(1, 8'h02, 16'd10, 16'd6, 16'hDEAD, 0);
        chk("R8 store err", 32'(gerr[1]), 1);
        issue(2, 8'h06, 0, 16'd1, 16'hDEAD, 16'h0020);
        chk("R8 stind err", 32'(gerr[2]), 1);
        issue(3, 8'h15, 16'd17, 0, fill(1), 16'hDEAD);
        chk("R8 cas err", 32'(gerr[3]), 1);
        issue(0, 8'h01, 0, 0, 0, 0);
        chk("R8 word0 kept", 32'(got[0]), 32'(fill(0)));
        issue(0, 8'h01, 0, 1, 0, 0);
        chk("R8 word1 kept", 32'(got[0]), 32'(fill(1)));

        // R11: unsupported opcodes halt with error and write nothing
        issue(2, 8'h07, 0, 2, 16'hDEAD, 16'hDEAD);
        chk("R11 err", 32'(gerr[2]), 1);
        issue(3, 8'h00, 0, 2, 16'hDEAD, 16'hDEAD);
        chk("R11 err halt", 32'(gerr[3]), 1);
        issue(2, 8'h01, 0, 2, 0, 0);
        chk("R11 word kept", 32'(got[2]), 32'(fill(2)));

        // R5/R10: matching exchange writes, returns operand a, three-edge latency
        issue(2, 8'h15, 16'd2, 16'd3, fill(5), 16'hBEEF);
        chk("R5 result", 32'(got[2]), 32'(fill(5)));
        chk("R5 err", 32'(gerr[2]), 0);
        chk("R10 cas latency", 32'(lat[2]), 3);
        issue(0, 8'h01, 0, 5, 0, 0);
        chk("R5 mem", 32'(got[0]), 16'hBEEF);

        // R6: mismatching exchange returns the word and leaves memory
        issue(3, 8'h15, 0, 16'd5, 16'h1234, 16'h7777);
        chk("R6 result", 32'(got[3]), 16'hBEEF);
        chk("R10 fail latency", 32'(lat[3]), 2);
        issue(1, 8'h01, 0, 5, 0, 0);
        chk("R6 mem", 32'(got[1]), 16'hBEEF);

        // R7: a request arriving during a locked exchange waits for its done
        fork
            issue(0, 8'h15, 0, 16'd6, fill(6), 16'hAAAA);
            begin
                @(negedge clk);
                issue(1, 8'h15, 0, 16'd6, fill(6), 16'h5555);
            end
        join
        chk("R7 grant after done", 32'(gnt_at[1] >= done_at[0]), 1);
        chk("R7 winner", 32'(got[0]), 32'(fill(6)));
        chk("R7 loser sees new", 32'(got[1]), 16'hAAAA);

        // R7: four exchanges expecting the same old value, exactly one wins
        fork
            issue(0, 8'h15, 0, 16'd7, fill(7), 16'h1000);
            issue(1, 8'h15, 0, 16'd7, fill(7), 16'h1001);
            issue(2, 8'h15, 0, 16'd7, fill(7), 16'h1002);
            issue(3, 8'h15, 0, 16'd7, fill(7), 16'h1003);
        join
        begin
            int wins = 0;
            int wp = 0;
            for (int p = 0; p < N; p++) if (got[p] == fill(7)) begin wins++; wp = p; end
            chk("R7 one winner", 32'(wins), 1);
            for (int p = 0; p < N; p++)
                if (p != wp) chk("R7 losers see winner", 32'(got[p]), 32'(16'h1000 + wp));
        end

        chk("R2 single ready", 32'(multi_rdy), 0);
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule